// File: doc/BRIEF.md
# DDS Phase Accumulator with Repetition Tracking

This block is the phase accumulator of a direct digital synthesizer. On every enabled rising clock edge it adds a frequency tuning word (FTW) to an N-bit phase register. When the sum reaches or goes past the capacity C = 2^N, the register keeps the remainder (sum − C) rather than restarting at zero. Each wrap produces a one-cycle overflow pulse. A second pulse marks the wraps that leave the phase at exactly zero.

A small tracking state machine measures how many accumulation steps separate two wraps that land exactly on zero. This is the grand repetition period, and for a fixed nonzero FTW it equals C divided by the largest power of two that divides the FTW. The state machine has three states:

- ST_MEASURE: counting from a known zero reference.
- ST_LOCKED: a period has been captured and is reported as valid.
- ST_SEEK: the FTW has changed and no zero reference exists yet.

Its transitions are:

- Reset → ST_MEASURE, because the reset state is a zero reference.
- Any state → ST_SEEK on an FTW change.
- Any state → ST_MEASURE on an FTW change whose step lands on zero.
- ST_SEEK → ST_MEASURE on a zero wrap.
- ST_MEASURE → ST_LOCKED on a zero wrap, which captures the period.
- ST_LOCKED → ST_LOCKED on each later zero wrap, which recaptures the period.

The period counter counts enabled steps only. When the enable is low, the phase, the pulses and the tracking state all hold.

Top module: `dds_phase_accum`

## Requirements
- R1: While the synchronous reset is high, the phase clears to 0, both pulses are low and the period-valid output is low. These values are visible in the first cycle after reset is released.
- R2: On each rising edge with enable high, the phase becomes (phase + FTW) mod 2^N, so it always lies in 0 to 2^N − 1. The FTW used is the value present at that edge, so a new FTW takes effect on the next edge.
- R3: The overflow pulse is high in exactly those cycles whose registered phase was produced by a sum of 2^N or more. It is high for one cycle per such step.
- R4: The zero-wrap pulse is high only in cycles where the overflow pulse is high and the phase is 0. When the FTW is a power of two below 2^N, every overflow raises it.
- R5: With enable low, the phase holds, both pulses are low, and the period counter does not advance.
- R6: For a fixed nonzero FTW applied from reset, the period-valid output rises after exactly P enabled steps, where P = 2^N / (largest power of two dividing FTW). From then on the period output equals P.
- R7: A change of FTW drops period-valid after the edge that sees it and restarts the counter. Valid returns only after a zero wrap followed by one full period.
- R8: With FTW = 0 the phase stays constant, no overflow occurs and period-valid stays low.
- R9: Whenever period-valid is high, the period output lies between 1 and 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accumulation enable |
| ftw | input | PHASE_W | Frequency tuning word |
| phase | output | PHASE_W | Registered phase value |
| ovf_pulse | output | 1 | High for the cycle after a step that wrapped |
| zero_pulse | output | 1 | High for the cycle after a step that wrapped to exactly 0 |
| period | output | PHASE_W+1 | Measured grand repetition period, in enabled steps |
| period_valid | output | 1 | Period output holds a complete measurement |

## Verification
A wrong phase register shows up at the phase port on the very next enabled edge. A wrong carry decision shows up on the overflow or zero pulse in the same cycle. A tracker that counts badly, counts while disabled, or misses an FTW change only shows up once a zero wrap occurs, which can be up to 2^N steps later. For that reason the bench sweeps every nonzero FTW of an 8-bit configuration and checks period-valid one step before and exactly at the predicted period. It also checks that the captured value is still correct one full period later.

// File: rtl/dds_pa_pkg.sv
package dds_pa_pkg;

    // Tracking states of the repetition-period measurement
    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_LOCKED  = 2'd2
    } grp_state_e;

endpackage

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase,
    output logic               ovf_pulse,
    output logic               zero_pulse,
    output logic               zero_step
);
    localparam int SUM_W = PHASE_W + 1;

    logic [SUM_W-1:0]   sum;
    logic [PHASE_W-1:0] phase_q;
    logic               ovf_q;
    logic               zero_q;
    logic               carry;
    logic               rem_is_zero;

    assign sum         = {1'b0, phase_q} + {1'b0, ftw};
    assign carry       = sum[PHASE_W];
    assign rem_is_zero = (sum[PHASE_W-1:0] == '0);
    assign zero_step   = en & carry & rem_is_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            ovf_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (en) begin
            phase_q <= sum[PHASE_W-1:0];
            ovf_q   <= carry;
            zero_q  <= carry & rem_is_zero;
        end else begin
            ovf_q   <= 1'b0;
            zero_q  <= 1'b0;
        end
    end

    assign phase      = phase_q;
    assign ovf_pulse  = ovf_q;
    assign zero_pulse = zero_q;

    // R4
    zero_needs_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> (ovf_pulse && phase == '0));

    // R3
    ovf_phase_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (phase < $past(phase)));

    // R2
    no_ovf_phase_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovf_pulse && $past(en) && !$past(rst)) |-> (phase >= $past(phase)));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase) && !ovf_pulse && !zero_pulse));

endmodule

// File: rtl/dds_ftw_watch.sv
module dds_ftw_watch #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] ftw,
    output logic               ftw_changed
);
    logic [PHASE_W-1:0] ftw_last;

    always_ff @(posedge clk) begin
        ftw_last <= ftw;
    end

    assign ftw_changed = !rst && (ftw != ftw_last);

endmodule

// File: rtl/dds_grp_tracker.sv
module dds_grp_tracker
    import dds_pa_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               zero_step,
    input  logic               ftw_changed,
    output logic [PHASE_W:0]   period,
    output logic               period_valid
);
    localparam int CNT_W = PHASE_W + 1;
    localparam logic [CNT_W-1:0] CAP = CNT_W'(1) << PHASE_W;

    grp_state_e       state_q;
    grp_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_MEASURE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ftw_changed) begin
            state_d = zero_step ? ST_MEASURE : ST_SEEK;
        end else begin
            unique case (state_q)
                ST_SEEK:    if (zero_step) state_d = ST_MEASURE;
                ST_MEASURE: if (zero_step) state_d = ST_LOCKED;
                ST_LOCKED:  state_d = ST_LOCKED;
                default:    state_d = ST_SEEK;
            endcase
        end
    end

    // Counter and period outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
        end else if (ftw_changed) begin
            cnt_q    <= '0;
            period_q <= '0;
        end else if (en && state_q != ST_SEEK) begin
            if (zero_step) begin
                period_q <= cnt_q + 1'b1;
                cnt_q    <= '0;
            end else if (cnt_q != CAP) begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end

    assign period       = period_q;
    assign period_valid = (state_q == ST_LOCKED);

    // R9
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        period_valid |-> (period != '0 && period <= CAP));

    // R7
    change_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ftw_changed |=> !period_valid);

    // R6
    first_zero_locks_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_step && !ftw_changed && state_q == ST_MEASURE) |=> period_valid);

    // R5
    idle_counter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !ftw_changed) |=> ($stable(cnt_q) && $stable(period_valid)));

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase,
    output logic               ovf_pulse,
    output logic               zero_pulse,
    output logic [PHASE_W:0]   period,
    output logic               period_valid
);
    logic zero_step;
    logic ftw_changed;

    dds_phase_core #(.PHASE_W(PHASE_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .ftw        (ftw),
        .phase      (phase),
        .ovf_pulse  (ovf_pulse),
        .zero_pulse (zero_pulse),
        .zero_step  (zero_step)
    );

    dds_ftw_watch #(.PHASE_W(PHASE_W)) u_watch (
        .clk         (clk),
        .rst         (rst),
        .ftw         (ftw),
        .ftw_changed (ftw_changed)
    );

    dds_grp_tracker #(.PHASE_W(PHASE_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .zero_step    (zero_step),
        .ftw_changed  (ftw_changed),
        .period       (period),
        .period_valid (period_valid)
    );

endmodule

// File: tb/dds_phase_accum_tb.sv
`timescale 1ns/1ps
module dds_phase_accum_tb;
    localparam int W = 8;
    localparam int CAPV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] ftw = '0;
    logic [W-1:0] phase;
    logic         ovf_pulse, zero_pulse, period_valid;
    logic [W:0]   period;

    int n_chk = 0;
    int n_fail = 0;
    int mphase = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dds_phase_accum #(.PHASE_W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .ftw(ftw),
        .phase(phase), .ovf_pulse(ovf_pulse), .zero_pulse(zero_pulse),
        .period(period), .period_valid(period_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_period(input int f);
        return CAPV / (f & (~f + 1));
    endfunction

    // One clock edge, then compare the outputs against the arithmetic model
    task automatic step();
        int  s;
        bit  e_ovf, e_zero;
        @(posedge clk);
        #1;
        if (en) begin
            s      = mphase + int'(ftw);
            e_ovf  = (s >= CAPV);
            mphase = s % CAPV;
            e_zero = e_ovf && (mphase == 0);
            chk(int'(phase) == mphase, "R2 phase", int'(phase), mphase);
            chk(ovf_pulse == e_ovf, "R3 overflow", int'(ovf_pulse), int'(e_ovf));
            chk(zero_pulse == e_zero, "R4 zero wrap", int'(zero_pulse), int'(e_zero));
            if (ovf_pulse && ftw != 0 && (ftw & (ftw - 1'b1)) == 0)
                chk(zero_pulse == 1'b1, "R4 pow2 remainder", int'(zero_pulse), 1);
        end else begin
            chk(int'(phase) == mphase, "R5 phase hold", int'(phase), mphase);
            chk(!ovf_pulse && !zero_pulse, "R5 pulses idle",
                int'({ovf_pulse, zero_pulse}), 0);
        end
    endtask

    task automatic do_reset(input int f);
        ftw = W'(f);
        en  = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        mphase = 0;
        chk(phase == '0 && !ovf_pulse && !zero_pulse && !period_valid, "R1 reset state",
            int'({phase, ovf_pulse, zero_pulse, period_valid}), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Sweep every nonzero FTW from reset (R6, R9)
        for (int f = 1; f < CAPV; f++) begin
            int p;
            p = exp_period(f);
            do_reset(f);
            for (int k = 1; k < p; k++) step();
            chk(!period_valid, "R6 valid before period", int'(period_valid), 0);
            step();
            chk(period_valid && int'(period) == p, "R6 period captured", int'(period), p);
            chk(int'(period) >= 1 && int'(period) <= CAPV, "R9 period range", int'(period), p);
            for (int k = 0; k < p; k++) step();
            chk(period_valid && int'(period) == p, "R6 period repeats", int'(period), p);
        end

        // FTW = 0 (R8)
        do_reset(0);
        for (int k = 0; k < 300; k++) step();
        chk(!period_valid && phase == '0, "R8 zero ftw", int'(period_valid), 0);

        // Enable low pauses the counter (R5)
        do_reset(3);
        for (int k = 0; k < 100; k++) step();
        en = 1'b0;
        for (int k = 0; k < 20; k++) step();
        en = 1'b1;
        for (int k = 0; k < 155; k++) step();
        chk(!period_valid, "R5 counter paused", int'(period_valid), 0);
        step();
        chk(period_valid && int'(period) == 256, "R5 period after pause", int'(period), 256);

        // FTW change mid-run (R7)
        do_reset(1);
        for (int k = 0; k < 300; k++) step();
        chk(period_valid && int'(period) == 256, "R7 locked before change", int'(period), 256);
        ftw = W'(12);
        step();
        chk(!period_valid, "R7 valid drops on change", int'(period_valid), 0);
        begin
            int guard = 0;
            while (!(zero_pulse) && guard < 400) begin
                step();
                guard++;
            end
        end
        chk(!period_valid, "R7 still invalid at first zero", int'(period_valid), 0);
        for (int k = 1; k < 64; k++) step();
        chk(!period_valid, "R7 invalid before full period", int'(period_valid), 0);
        step();
        chk(period_valid && int'(period) == 64, "R7 relocked period", int'(period), 64);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule